// File: doc/BRIEF.md
# Code-region patch and breakpoint redirector

This block sits beside the core's code-bus path and inspects every request aimed at the low code region. A bank of instruction comparators looks at instruction fetches and a smaller bank of literal comparators looks at data loads. When an enabled comparator matches the word address of a request, the block redirects the request into a small patch table held in RAM. The slot in that table is the comparator's number. Instead of redirecting, an instruction comparator can hand the core a breakpoint opcode in one or both halfwords of the fetched word.

The flash request that caused the match has already left, because the decision comes too late to stop it. The block therefore tells the core two things: the original response is to be dropped, and the redirected address is the one to use. The untouched request address is also exported, so that protection checks can run on the address the software actually issued. A small register-write port sets up the global enable, the patch-table base and each comparator. Results appear one clock after the request.

Top module: `code_patch_unit`

## Requirements
- R1: After reset every enable is clear and out_valid, out_redirect, out_bkpt and out_addr are all zero.
- R2: A comparator takes part in matching only while both its own enable bit and the global enable are set. Clearing either one stops all redirection and breakpoint substitution by that comparator.
- R3: When an instruction comparator in remap mode matches a fetch, out_redirect is 1 and out_addr equals the patch base (bits [31:5]) with bits [4:2] set to the comparator number and bits [1:0] taken from the request.
- R4: Comparators 0 to 5 match only fetches (req_kind 0). Comparators 6 and 7 match only loads (req_kind 1). A request of the other kind is never redirected by that bank.
- R5: A load that is not naturally aligned is never redirected, even when its word address matches. A halfword load needs address bit 0 clear and a word load needs bits [1:0] clear. Byte loads are always aligned. req_size is 0 for a byte, 1 for a halfword and 2 for a word.
- R6: The replace field of an instruction comparator works as follows. 0 means remap. 1 replaces the lower halfword of the data with 0xBE00. 2 replaces the upper halfword. 3 replaces both. In any mode other than 0, out_bkpt is 1, out_redirect is 0, out_addr is the original address, and any halfword that is not replaced keeps the flash data.
- R7: When several enabled comparators match the same request, the one with the lowest number decides the result. This also decides between breakpoint mode and remap mode.
- R8: Only addresses with bits [31:29] equal to zero can match. The comparison uses address bits [28:2].
- R9: out_orig_addr always carries the request address unchanged. out_addr equals that address whenever out_redirect is 0. out_rdata equals flash_rdata whenever out_bkpt is 0.
- R10: Each request with req_valid high gives exactly one result, with out_valid high, in the following clock cycle. No result appears without a request.
- R11: Configuration writes are decoded on cfg_sel. Select 0 sets the global enable from bit 0. Select 1 sets the patch base from bits [31:5]. Select 2+n sets comparator n: enable in bit 0, word address in bits [28:2] and replace field in bits [31:30]. The replace field is ignored for literal comparators, which always remap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_kind | input | 1 | 0 instruction fetch, 1 literal load |
| flash_rdata | input | 32 | Flash data for the request of the previous cycle |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_redirect | output | 1 | Drop the flash response and use out_addr |
| out_bkpt | output | 1 | out_rdata carries a breakpoint substitute |
| out_addr | output | 32 | Redirected address, or the original one |
| out_orig_addr | output | 32 | Unmodified request address for protection checks |
| out_rdata | output | 32 | Flash data with breakpoint halfwords merged in |

## Verification
The bench puts two comparators on one address. A design with an inverted priority chain would report the higher slot number in out_addr, or it would choose remap where breakpoint was expected. Misaligned literal loads of each size are sent next to aligned loads at the same word. A design that skipped the alignment gate, or applied it to the wrong size, would redirect 0x2002 as a word load or refuse it as a halfword load. Addresses that differ from a comparator's address only above bit 28 check that region gating is done apart from the compare. Each replace code is checked against the merged data, which exposes swapped halfwords. Back-to-back requests followed by idle cycles show any lost, doubled or stray results.

// File: rtl/cpatch_pkg.sv
package cpatch_pkg;
   localparam int unsigned AW = 32;

   typedef enum logic {
      ACC_FETCH = 1'b0,
      ACC_LOAD  = 1'b1
   } acc_kind_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [1:0] {
      RP_REMAP = 2'd0,
      RP_LOW   = 2'd1,
      RP_HIGH  = 2'd2,
      RP_BOTH  = 2'd3
   } rep_mode_e;

   // comparator setup; word holds address bits [28:2]
   typedef struct packed {
      logic      en;
      logic [26:0] word;
      rep_mode_e rep;
   } cmp_cfg_t;
endpackage

// File: rtl/cpatch_cfg.sv
module cpatch_cfg
   import cpatch_pkg::*;
#(
   parameter int unsigned N_INSN = 6,
   parameter int unsigned N_LIT  = 2,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned BASE_LSB = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [AW-1:0]               wdata,
   output logic                        glob_en,
   output logic [AW-1:BASE_LSB]        base,
   output cmp_cfg_t [N_INSN+N_LIT-1:0] cmp_cfg
);
   localparam int unsigned N_CMP = N_INSN + N_LIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         base    <= '0;
      end else if (we) begin
         if (sel == SEL_W'(0)) glob_en <= wdata[0];
         if (sel == SEL_W'(1)) base    <= wdata[AW-1:BASE_LSB];
      end
   end

   for (genvar i = 0; i < N_CMP; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_cfg[i] <= '0;
         end else if (we && sel == SEL_W'(i + 2)) begin
            cmp_cfg[i].en   <= wdata[0];
            cmp_cfg[i].word <= wdata[28:2];
            if (i < N_INSN) cmp_cfg[i].rep <= rep_mode_e'(wdata[31:30]);
            else            cmp_cfg[i].rep <= RP_REMAP;
         end
      end
   end
endmodule

// File: rtl/cpatch_cmp.sv
module cpatch_cmp
   import cpatch_pkg::*;
#(
   parameter bit IS_LIT = 1'b0
) (
   input  cmp_cfg_t        cfg,
   input  logic            glob_en,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic [1:0]      req_size,
   input  logic            req_kind,
   output logic            hit
);
   logic in_region, addr_eq, kind_ok, align_ok;

   assign in_region = (req_addr[AW-1:29] == '0);
   assign addr_eq   = (req_addr[28:2] == cfg.word);

   if (IS_LIT) begin : g_lit
      assign kind_ok = (req_kind == ACC_LOAD);
      always_comb begin
         unique case (req_size)
            SZ_HALF: align_ok = ~req_addr[0];
            SZ_WORD: align_ok = (req_addr[1:0] == 2'b00);
            default: align_ok = 1'b1;
         endcase
      end
   end else begin : g_insn
      assign kind_ok  = (req_kind == ACC_FETCH);
      assign align_ok = 1'b1;
   end

   assign hit = req_valid & glob_en & cfg.en & in_region & addr_eq & kind_ok & align_ok;
endmodule

// File: rtl/cpatch_pick.sv
module cpatch_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end
   assign any = |hits;
endmodule

// File: rtl/code_patch_unit.sv
module code_patch_unit
   import cpatch_pkg::*;
#(
   parameter int unsigned N_INSN  = 6,
   parameter int unsigned N_LIT   = 2,
   parameter logic [15:0] BKPT_OP = 16'hBE00,
   localparam int unsigned N_CMP    = N_INSN + N_LIT,
   localparam int unsigned IDX_W    = (N_CMP > 1) ? $clog2(N_CMP) : 1,
   localparam int unsigned SEL_W    = $clog2(N_CMP + 2),
   localparam int unsigned BASE_LSB = IDX_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_addr,
   input  logic [1:0]       req_size,
   input  logic             req_kind,
   input  logic [AW-1:0]    flash_rdata,
   output logic             out_valid,
   output logic             out_redirect,
   output logic             out_bkpt,
   output logic [AW-1:0]    out_addr,
   output logic [AW-1:0]    out_orig_addr,
   output logic [AW-1:0]    out_rdata
);
   if (N_INSN < 1 || N_LIT < 1) begin : g_bad_count
      $error("code_patch_unit: each bank needs at least one comparator");
   end
   if (N_CMP != 8) begin : g_bad_slots
      $error("code_patch_unit: register layout assumes eight comparators");
   end

   logic                  glob_en;
   logic [AW-1:BASE_LSB]  base;
   cmp_cfg_t [N_CMP-1:0]  cmp_cfg;
   logic [N_CMP-1:0]      hits;
   logic                  any_hit;
   logic [IDX_W-1:0]      win;
   rep_mode_e             win_rep;
   rep_mode_e             rep_q;

   cpatch_cfg #(
      .N_INSN(N_INSN), .N_LIT(N_LIT), .SEL_W(SEL_W), .BASE_LSB(BASE_LSB)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .glob_en(glob_en), .base(base), .cmp_cfg(cmp_cfg)
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      cpatch_cmp #(.IS_LIT(i >= N_INSN)) i_cmp (
         .cfg(cmp_cfg[i]), .glob_en(glob_en), .req_valid(req_valid),
         .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
         .hit(hits[i])
      );
   end

   cpatch_pick #(.N(N_CMP), .IDX_W(IDX_W)) i_pick (
      .hits(hits), .any(any_hit), .idx(win)
   );

   assign win_rep = any_hit ? cmp_cfg[win].rep : RP_REMAP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_redirect  <= 1'b0;
         out_bkpt      <= 1'b0;
         out_addr      <= '0;
         out_orig_addr <= '0;
         rep_q         <= RP_REMAP;
      end else begin
         out_valid     <= req_valid;
         out_orig_addr <= req_addr;
         rep_q         <= win_rep;
         out_bkpt      <= any_hit && (win_rep != RP_REMAP);
         out_redirect  <= any_hit && (win_rep == RP_REMAP);
         if (any_hit && win_rep == RP_REMAP)
            out_addr <= {base, win, req_addr[1:0]};
         else
            out_addr <= req_addr;
      end
   end

   always_comb begin
      out_rdata = flash_rdata;
      if (out_bkpt) begin
         if (rep_q == RP_LOW  || rep_q == RP_BOTH) out_rdata[15:0]  = BKPT_OP;
         if (rep_q == RP_HIGH || rep_q == RP_BOTH) out_rdata[31:16] = BKPT_OP;
      end
   end

   // ---------------- assertions ----------------
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_redirect && out_bkpt)) else $error("redirect and breakpoint together"); // R6

   AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(glob_en) |-> !out_redirect && !out_bkpt); // R2

   AST_ORIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_orig_addr == $past(req_addr)); // R9

   AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(req_valid)); // R10

   AST_SLOT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_redirect |-> out_addr[AW-1:BASE_LSB] == $past(base)); // R3

   AST_REGION_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_addr[AW-1:29] != 3'b000) |-> !out_redirect && !out_bkpt); // R8

   AST_UNALIGNED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_kind == ACC_LOAD && req_size == SZ_WORD && req_addr[1:0] != 2'b00)
      |-> !out_redirect); // R5

   AST_LOAD_NO_BKPT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_kind == ACC_LOAD) |-> !out_bkpt); // R4
endmodule

// File: tb/test_code_patch_unit.sv
`timescale 1ns/1ps
module test_code_patch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_kind = 1'b0;
   logic [31:0] flash_rdata;
   logic        out_valid, out_redirect, out_bkpt;
   logic [31:0] out_addr, out_orig_addr, out_rdata;

   always #4 clk = ~clk;

   code_patch_unit i_code_patch_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_kind(req_kind), .flash_rdata(flash_rdata),
      .out_valid(out_valid), .out_redirect(out_redirect), .out_bkpt(out_bkpt),
      .out_addr(out_addr), .out_orig_addr(out_orig_addr), .out_rdata(out_rdata)
   );

   function automatic logic [31:0] fdat(input logic [31:0] a);
      return {a[15:0] ^ 16'hA5A5, a[15:0]};
   endfunction
   assign flash_rdata = fdat(out_orig_addr);

   typedef struct packed {
      logic        redir;
      logic        bkpt;
      logic [31:0] addr;
      logic [31:0] orig;
      logic [31:0] data;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;

   // bench-side copy of configuration
   logic        m_gen = 0;
   logic [31:0] m_base = 0;
   logic        m_en[8];
   logic [26:0] m_word[8];
   logic [1:0]  m_rep[8];

   function automatic exp_t model(input logic [31:0] a, input logic [1:0] sz, input logic k);
      exp_t e;
      int   w;
      e.redir = 0; e.bkpt = 0; e.addr = a; e.orig = a; e.data = fdat(a);
      if (!m_gen || a[31:29] != 3'b000) return e;
      if (k && ((sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00))) return e;
      w = -1;
      for (int i = (k ? 6 : 0); i < (k ? 8 : 6); i++)
         if (w < 0 && m_en[i] && m_word[i] == a[28:2]) w = i;
      if (w < 0) return e;
      if (!k && m_rep[w] != 2'd0) begin
         e.bkpt = 1;
         if (m_rep[w][0]) e.data[15:0]  = 16'hBE00;
         if (m_rep[w][1]) e.data[31:16] = 16'hBE00;
      end else begin
         e.redir = 1;
         e.addr  = {m_base[31:5], w[2:0], a[1:0]};
      end
      return e;
   endfunction

   task automatic wr(input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      req_valid = 0; cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
      if (sel == 0) m_gen = d[0];
      else if (sel == 1) m_base = {d[31:5], 5'd0};
      else begin
         m_en[sel-2] = d[0]; m_word[sel-2] = d[28:2];
         m_rep[sel-2] = (sel - 2 < 6) ? d[31:30] : 2'd0;
      end
   endtask

   task automatic cmp_set(input int n, input logic en, input logic [31:0] a, input logic [1:0] rep);
      wr(4'(n + 2), {rep, 1'b0, a[28:2], 1'b0, en});
   endtask

   task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic k, input string tag);
      @(negedge clk);
      cfg_we = 0; req_valid = 1; req_addr = a; req_size = sz; req_kind = k;
      exp_q.push_back(model(a, sz, k));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_we = 0; req_valid = 0;
      end
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #2;
      if (rst_n && out_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10 stray result addr=%h expected no result", out_orig_addr);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (out_redirect !== e.redir || out_bkpt !== e.bkpt || out_addr !== e.addr ||
                out_orig_addr !== e.orig || out_rdata !== e.data) begin
               n_bad++;
               $display("FAIL %s R9 got redir=%b bkpt=%b addr=%h orig=%h data=%h expected redir=%b bkpt=%b addr=%h orig=%h data=%h",
                        t, out_redirect, out_bkpt, out_addr, out_orig_addr, out_rdata,
                        e.redir, e.bkpt, e.addr, e.orig, e.data);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired, got running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_word[i] = 0; m_rep[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      n_chk++;
      if (out_valid !== 0 || out_redirect !== 0 || out_bkpt !== 0 || out_addr !== 0) begin
         n_bad++;
         $display("FAIL R1 reset outputs %b%b%b %h expected 000 0", out_valid, out_redirect, out_bkpt, out_addr);
      end
      rst_n = 1;
      idle(2);

      // R2: nothing before enables
      send(32'h0000_0100, 2'd2, 1'b0, "R2 all off");
      wr(1, 32'h2000_015F);                 // R11 base low bits dropped
      cmp_set(0, 1, 32'h0000_0100, 2'd0);
      send(32'h0000_0100, 2'd2, 1'b0, "R2 global off");
      wr(0, 32'h1);
      send(32'h0000_0100, 2'd2, 1'b0, "R3 slot0");
      send(32'h0000_0102, 2'd1, 1'b0, "R3 slot0 half");
      cmp_set(0, 0, 32'h0000_0100, 2'd0);
      send(32'h0000_0100, 2'd2, 1'b0, "R2 local off");
      cmp_set(3, 1, 32'h0800_1234, 2'd0);
      send(32'h0800_1236, 2'd1, 1'b0, "R3 slot3");
      send(32'h0800_1238, 2'd2, 1'b0, "R8 next word");
      idle(2);

      // R7 priority
      cmp_set(1, 1, 32'h0000_0400, 2'd0);
      cmp_set(4, 1, 32'h0000_0400, 2'd0);
      send(32'h0000_0400, 2'd2, 1'b0, "R7 lowest 1");
      cmp_set(1, 0, 32'h0000_0400, 2'd0);
      send(32'h0000_0400, 2'd2, 1'b0, "R7 falls to 4");
      cmp_set(2, 1, 32'h0000_0400, 2'd1);
      send(32'h0000_0400, 2'd2, 1'b0, "R7 bkpt wins");

      // R6 replace codes
      cmp_set(2, 1, 32'h0000_0600, 2'd1);
      cmp_set(5, 1, 32'h0000_0700, 2'd2);
      cmp_set(0, 1, 32'h0000_0800, 2'd3);
      send(32'h0000_0600, 2'd2, 1'b0, "R6 low");
      send(32'h0000_0700, 2'd2, 1'b0, "R6 high");
      send(32'h0000_0802, 2'd1, 1'b0, "R6 both");

      // R4 / R5 literal bank
      cmp_set(6, 1, 32'h0000_2000, 2'd0);
      cmp_set(7, 1, 32'h0000_3000, 2'd3);
      send(32'h0000_2000, 2'd2, 1'b1, "R4 load slot6");
      send(32'h0000_2000, 2'd2, 1'b0, "R4 fetch vs literal");
      send(32'h0000_0800, 2'd2, 1'b1, "R4 load vs insn");
      send(32'h0000_2002, 2'd2, 1'b1, "R5 word misaligned");
      send(32'h0000_2002, 2'd1, 1'b1, "R5 half aligned");
      send(32'h0000_2001, 2'd1, 1'b1, "R5 half misaligned");
      send(32'h0000_2003, 2'd0, 1'b1, "R5 byte");
      send(32'h0000_3000, 2'd2, 1'b1, "R11 literal rep ignored");

      // R8 region
      send(32'h2000_0800, 2'd2, 1'b0, "R8 outside region");
      send(32'h1000_0800, 2'd2, 1'b0, "R8 bit28 differs");
      send(32'hE000_2000, 2'd2, 1'b1, "R8 high load");
      idle(3);

      // R10 back to back after new base
      wr(1, 32'h3000_0000);
      for (int i = 0; i < 6; i++)
         send(32'h0000_0800 + 32'(i * 4), 2'd2, 1'b0, "R10 burst");
      idle(4);

      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10 results missing got %0d left expected 0", exp_q.size());
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule